// File: doc/BRIEF.md
# Gatable Multivibrator Controller

A clocked multivibrator that can run free as a gated square-wave source or act as a one-shot. A single programmable half-period value `H` stands in for an external timing network. One oscillator half-cycle (a "tick") lasts H+1 clock cycles. Every timing behaviour is a count of ticks. The modes are free-running astable, one-shot and retriggerable one-shot. All three share one counter and one output flip-flop, so only one mode is active at a time.

Free-running operation starts when either gate input is active. It stops as soon as both gates are inactive, so short pulses on a gate produce bursts of square wave. A one-shot can start from a rising edge on the positive trigger or from a falling edge on the negative trigger. A retriggerable pulse starts from a rising edge that arrives on the retrigger input and the positive trigger together. Its end is counted from the last release of the retrigger input. An external reset blanks the outputs at once and keeps the block idle.

Every control input passes through a two-stage synchroniser, and edges are taken from the synchronised levels. The outputs are Q, its complement QN, and the oscillator output OSC.

Top module: `mvib_ctrl`

## Requirements
- R1: After rst_ni is released, with no input active, q_o is 0, qn_o is 1 and osc_o is 0.
- R2: An input change is sampled by the first rising clock edge. The resulting change of q_o happens two rising edges later, so it is first visible at the third falling edge after the input change.
- R3: A rising edge on trig_pos_i while trig_neg_i is low makes q_o high for exactly 4*(H+1) clock cycles. A rising edge on trig_pos_i while trig_neg_i is high produces no pulse.
- R4: A falling edge on trig_neg_i while trig_pos_i is high makes q_o high for exactly 4*(H+1) clock cycles.
- R5: Further trigger edges during a one-shot pulse do not move its end. The pulse stays 4*(H+1) cycles long, counted from the first trigger.
- R6: With the block idle, the oscillator starts when gate_i is 1 or gate_ni is 0. The first high phase of q_o lasts 4*(H+1) cycles. Every later low or high phase lasts 2*(H+1) cycles.
- R7: While the oscillator runs, osc_o toggles every H+1 cycles, so its period is half that of q_o. Whenever the block is idle, osc_o is 0.
- R8: When gate_i is 0 and gate_ni is 1, the oscillator stops: q_o and osc_o are 0 at the third falling edge after the change.
- R9: A rising edge on retrig_i and trig_pos_i together starts a pulse. q_o stays high while retrig_i is held. After retrig_i returns low, q_o stays high for 3*(H+1)+1 further falling edges and then falls. That moment is the third tick, which is the second rising edge of OSC after the release.
- R10: A new common rising edge on retrig_i and trig_pos_i, arriving before a retriggerable pulse ends, keeps q_o high without a gap. The end is then counted again, as in R9, from the new release.
- R11: While ext_rst_i is 1, q_o is 0 and qn_o is 1 in the same cycle, and any pulse in progress is aborted. While ext_rst_i stays high, no trigger or gate produces a pulse.
- R12: qn_o is always the complement of q_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_i | input | HALF_W | Half-period value H; one tick is H+1 cycles |
| trig_pos_i | input | 1 | Positive-edge trigger |
| trig_neg_i | input | 1 | Negative-edge trigger |
| gate_i | input | 1 | Oscillator gate, active high |
| gate_ni | input | 1 | Oscillator gate, active low |
| retrig_i | input | 1 | Retrigger, driven together with trig_pos_i |
| ext_rst_i | input | 1 | External reset, active high |
| q_o | output | 1 | Main output Q |
| qn_o | output | 1 | Complement of Q |
| osc_o | output | 1 | Oscillator output |

## Verification
The hardest state to reach is a retriggerable pulse that is extended in the middle of its end countdown. It needs a common rising edge on retrig_i and trig_pos_i that lands after the countdown has started but before its third tick. The bench releases the first retrigger, waits fewer cycles than the countdown, and raises both inputs again. It then checks that q_o shows no low sample in between, and that the remaining width is measured from the second release. A second hard case is the external reset arriving mid-pulse, since the output must drop in the same cycle: the bench samples q_o one time step after raising ext_rst_i, before any clock edge.

// File: rtl/mvib_pkg.sv
package mvib_pkg;
  typedef enum logic [1:0] {MV_IDLE, MV_FREE, MV_SHOT, MV_HOLD} mv_state_e;

  localparam int NUM_IN      = 6;
  localparam int IX_POS      = 0;
  localparam int IX_NEG      = 1;
  localparam int IX_GATE     = 2;
  localparam int IX_GATEN    = 3;
  localparam int IX_RTG      = 4;
  localparam int IX_EXT      = 5;
  // gate_ni idles high; all others idle low
  localparam logic [NUM_IN-1:0] IN_RST_VAL = 6'b001000;

  localparam int SYNC_STAGES = 2;
  localparam int SHOT_TICKS  = 4;  // one-shot width, two osc periods
  localparam int FIRST_TICKS = 4;  // first astable high phase
  localparam int PHASE_TICKS = 2;  // later astable phases
  localparam int HOLD_TICKS  = 3;  // retrigger tail after release
  localparam int TICK_CW     = $clog2(FIRST_TICKS);
endpackage

// File: rtl/mvib_sync.sv
module mvib_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/mvib_timebase.sv
module mvib_timebase #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] half_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mvib_core.sv
module mvib_core
  import mvib_pkg::*;
#(
  parameter int TCW = TICK_CW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] lvl_i,
  input  logic              tick_i,
  output logic              run_o,
  output mv_state_e         st_o,
  output logic              q_o,
  output logic              osc_o
);
  localparam logic [TCW-1:0] LAST_SHOT  = TCW'(SHOT_TICKS - 1);
  localparam logic [TCW-1:0] LAST_FIRST = TCW'(FIRST_TICKS - 1);
  localparam logic [TCW-1:0] LAST_PHASE = TCW'(PHASE_TICKS - 1);
  localparam logic [TCW-1:0] LAST_HOLD  = TCW'(HOLD_TICKS - 1);

  mv_state_e      st_q;
  logic           q_q, osc_q, first_q;
  logic [TCW-1:0] tcnt_q;
  logic [2:0]     prev_q;  // {retrig, neg, pos}

  logic pos_s, neg_s, rtg_s, ext_s, gate_on;
  logic pos_rise, neg_fall, rtg_rise;
  logic ev_shot, ev_rtg, phase_end;

  assign pos_s   = lvl_i[IX_POS];
  assign neg_s   = lvl_i[IX_NEG];
  assign rtg_s   = lvl_i[IX_RTG];
  assign ext_s   = lvl_i[IX_EXT];
  assign gate_on = lvl_i[IX_GATE] | ~lvl_i[IX_GATEN];

  assign pos_rise = pos_s & ~prev_q[0];
  assign neg_fall = ~neg_s & prev_q[1];
  assign rtg_rise = rtg_s & ~prev_q[2];

  assign ev_rtg  = rtg_rise & pos_rise;
  assign ev_shot = (pos_rise & ~neg_s) | (neg_fall & pos_s);

  assign phase_end = first_q ? (tcnt_q == LAST_FIRST) : (tcnt_q == LAST_PHASE);

  // retrigger pulse holds its countdown while retrig is high
  assign run_o = (st_q == MV_FREE) || (st_q == MV_SHOT) ||
                 ((st_q == MV_HOLD) && !rtg_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 3'b000;
    else         prev_q <= {rtg_s, neg_s, pos_s};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= MV_IDLE;
      q_q     <= 1'b0;
      osc_q   <= 1'b0;
      tcnt_q  <= '0;
      first_q <= 1'b1;
    end else if (ext_s) begin
      st_q    <= MV_IDLE;
      q_q     <= 1'b0;
      osc_q   <= 1'b0;
      tcnt_q  <= '0;
      first_q <= 1'b1;
    end else begin
      unique case (st_q)
        MV_IDLE: begin
          tcnt_q  <= '0;
          osc_q   <= 1'b0;
          first_q <= 1'b1;
          if (gate_on) begin
            st_q <= MV_FREE;
            q_q  <= 1'b1;
          end else if (ev_rtg) begin
            st_q <= MV_HOLD;
            q_q  <= 1'b1;
          end else if (ev_shot) begin
            st_q <= MV_SHOT;
            q_q  <= 1'b1;
          end
        end
        MV_FREE: begin
          if (!gate_on) begin
            st_q  <= MV_IDLE;
            q_q   <= 1'b0;
            osc_q <= 1'b0;
          end else if (tick_i) begin
            osc_q <= ~osc_q;
            if (phase_end) begin
              q_q     <= ~q_q;
              tcnt_q  <= '0;
              first_q <= 1'b0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        MV_SHOT: begin
          if (tick_i) begin
            if (tcnt_q == LAST_SHOT) begin
              st_q  <= MV_IDLE;
              q_q   <= 1'b0;
              osc_q <= 1'b0;
            end else begin
              osc_q  <= ~osc_q;
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        MV_HOLD: begin
          if (ev_rtg) begin
            tcnt_q <= '0;
            osc_q  <= 1'b0;
          end else if (tick_i) begin
            if (tcnt_q == LAST_HOLD) begin
              st_q  <= MV_IDLE;
              q_q   <= 1'b0;
              osc_q <= 1'b0;
            end else begin
              osc_q  <= ~osc_q;
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assign st_o  = st_q;
  assign q_o   = q_q;
  assign osc_o = osc_q;
endmodule

// File: rtl/mvib_ctrl.sv
module mvib_ctrl
  import mvib_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_i,
  input  logic              trig_pos_i,
  input  logic              trig_neg_i,
  input  logic              gate_i,
  input  logic              gate_ni,
  input  logic              retrig_i,
  input  logic              ext_rst_i,
  output logic              q_o,
  output logic              qn_o,
  output logic              osc_o
);
  logic [NUM_IN-1:0] raw_in, lvl;
  logic              tb_run, tb_tick;
  mv_state_e         core_st;
  logic              core_q, core_osc;

  assign raw_in = {ext_rst_i, retrig_i, gate_ni, gate_i, trig_neg_i, trig_pos_i};

  mvib_sync #(
    .W      (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_RST_VAL)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (lvl)
  );

  mvib_timebase #(
    .CW(HALF_W)
  ) u_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (tb_run),
    .half_i(half_i),
    .tick_o(tb_tick)
  );

  mvib_core u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .tick_i(tb_tick),
    .run_o (tb_run),
    .st_o  (core_st),
    .q_o   (core_q),
    .osc_o (core_osc)
  );

  // raw reset blanks outputs before the synchronised path clears state
  assign q_o   = core_q & ~ext_rst_i;
  assign qn_o  = ~q_o;
  assign osc_o = core_osc & ~ext_rst_i;
endmodule

// File: rtl/mvib_ctrl_chk.sv
module mvib_ctrl_chk
  import mvib_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      ext_rst_i,
  input logic      tick,
  input mv_state_e st,
  input logic      q_r,
  input logic      osc_r
);
  a_r7_osc_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == MV_IDLE) |-> !osc_r);

  a_r3_shot_q_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == MV_SHOT) |-> q_r);

  a_r7_osc_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st != MV_HOLD) && (st == $past(st)) && !$past(tick)) |-> $stable(osc_r));

  a_r11_ext_holds_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_i && $past(ext_rst_i) && $past(ext_rst_i, 2) && $past(ext_rst_i, 3))
      |-> (!q_r && (st == MV_IDLE)));

  a_r6_tick_only_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (st != MV_IDLE));
endmodule

bind mvib_ctrl mvib_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ext_rst_i(ext_rst_i),
  .tick     (tb_tick),
  .st       (core_st),
  .q_r      (core_q),
  .osc_r    (core_osc)
);

// File: tb/mvib_ctrl_bench.sv
module mvib_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 16;
  localparam logic [1:0] K_POS = 2'd0, K_NEG = 2'd1, K_RTG = 2'd2;
  localparam int NVEC = 8;
  // {expected width, H, kind}
  localparam logic [33:0] VECS [NVEC] = '{
    {16'(4*(0+1)),   16'd0, K_POS},
    {16'(4*(1+1)),   16'd1, K_POS},
    {16'(4*(3+1)),   16'd3, K_POS},
    {16'(4*(7+1)),   16'd7, K_POS},
    {16'(4*(2+1)),   16'd2, K_NEG},
    {16'(4*(5+1)),   16'd5, K_NEG},
    {16'(3*(0+1)+1), 16'd0, K_RTG},
    {16'(3*(4+1)+1), 16'd4, K_RTG}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] half = '0;
  logic trig_pos = 0, trig_neg = 0, gate = 0, gate_n = 1, retrig = 0, ext_rst = 0;
  logic q_o, qn_o, osc_o;

  int n_chk = 0, n_fail = 0, qn_err = 0;
  bit done = 0;

  mvib_ctrl #(.HALF_W(HW)) u_mvib_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .half_i(half),
    .trig_pos_i(trig_pos), .trig_neg_i(trig_neg),
    .gate_i(gate), .gate_ni(gate_n), .retrig_i(retrig), .ext_rst_i(ext_rst),
    .q_o(q_o), .qn_o(qn_o), .osc_o(osc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && (qn_o !== ~q_o)) qn_err++;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic measure(output int lat, output int w);
    lat = 0; w = 0;
    for (int j = 1; j <= 400; j++) begin
      @(negedge clk);
      if (lat == 0) begin
        if (q_o) lat = j;
      end else if (!q_o) begin
        w = j - lat;
        break;
      end
    end
    #1;
  endtask

  task automatic seg(logic val, output int n);
    n = 1;
    for (int j = 0; j < 400; j++) begin
      @(negedge clk);
      if (q_o == val) n++;
      else break;
    end
    #1;
  endtask

  task automatic count_high(int cycles, output int n);
    n = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (q_o) n++;
    end
    #1;
  endtask

  task automatic run_high(output int n);
    n = 0;
    for (int j = 0; j < 400; j++) begin
      @(negedge clk);
      if (q_o) n++;
      else break;
    end
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lat, w, n, lows;
    logic [15:0] h, ew;
    logic [1:0]  kind;

    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    chk(q_o == 0, "R1", "q after reset", q_o, 0);
    chk(qn_o == 1, "R1", "qn after reset", qn_o, 1);
    chk(osc_o == 0, "R1", "osc after reset", osc_o, 0);

    // table of one-shot and retrigger widths
    for (int i = 0; i < NVEC; i++) begin
      ew = VECS[i][33:18]; h = VECS[i][17:2]; kind = VECS[i][1:0];
      half = h;
      wait_n(4);
      case (kind)
        K_POS: begin
          trig_pos = 1;
          measure(lat, w);
          chk(lat == 3, "R2", "trigger latency", lat, 3);
          chk(w == int'(ew), "R3", "pos one-shot width", w, int'(ew));
          chk(osc_o == 0, "R7", "osc idle after pulse", osc_o, 0);
          trig_pos = 0;
        end
        K_NEG: begin
          trig_neg = 1;
          wait_n(4);
          trig_pos = 1;
          count_high(8, n);
          chk(n == 0, "R3", "pos edge with neg high ignored", n, 0);
          trig_neg = 0;
          measure(lat, w);
          chk(w == int'(ew), "R4", "neg one-shot width", w, int'(ew));
          trig_pos = 0;
        end
        default: begin
          trig_pos = 1; retrig = 1;
          wait_n(3);
          chk(q_o == 1, "R9", "retrigger pulse started", q_o, 1);
          wait_n(5);
          chk(q_o == 1, "R9", "held while retrig high", q_o, 1);
          trig_pos = 0; retrig = 0;
          run_high(n);
          chk(n == int'(ew), "R9", "tail after release", n, int'(ew));
        end
      endcase
      wait_n(6);
    end

    // R5: non-retriggerable one-shot
    half = 3;
    wait_n(2);
    trig_pos = 1;
    n = 0;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (q_o) n++;
      #1;
      if (j == 5) trig_pos = 0;
      if (j == 9) trig_pos = 1;
      if (j == 13) trig_pos = 0;
    end
    chk(n == 16, "R5", "width with extra trigger", n, 16);

    // R6/R7: astable via active-high gate, H=2
    half = 2;
    wait_n(2);
    gate = 1;
    measure(lat, w);
    chk(lat == 3, "R6", "astable start latency", lat, 3);
    chk(w == 12, "R6", "first high phase", w, 12);
    seg(1'b0, n);
    chk(n == 6, "R6", "low phase", n, 6);
    seg(1'b1, n);
    chk(n == 6, "R6", "later high phase", n, 6);
    for (int j = 0; j < 50; j++) begin @(negedge clk); if (!osc_o) break; end
    for (int j = 0; j < 50; j++) begin @(negedge clk); if (osc_o) break; end
    n = 1;
    for (int j = 0; j < 50; j++) begin @(negedge clk); if (osc_o) n++; else break; end
    #1;
    chk(n == 3, "R7", "osc high phase", n, 3);
    gate = 0;
    wait_n(3);
    chk(q_o == 0 && osc_o == 0, "R8", "stop on gate release", {q_o, osc_o}, 0);
    wait_n(4);

    // R6/R8: active-low gate, stop during first high phase
    gate_n = 0;
    wait_n(7);
    chk(q_o == 1, "R6", "active-low gate runs", q_o, 1);
    chk(osc_o == 1, "R7", "osc running", osc_o, 1);
    gate_n = 1;
    wait_n(3);
    chk(q_o == 0 && osc_o == 0, "R8", "stop on low gate release", {q_o, osc_o}, 0);
    wait_n(4);

    // R10: extension before the tail ends, H=3
    half = 3;
    wait_n(2);
    trig_pos = 1; retrig = 1;
    wait_n(4);
    trig_pos = 0; retrig = 0;
    lows = 0;
    for (int j = 0; j < 6; j++) begin @(negedge clk); if (!q_o) lows++; end
    #1;
    trig_pos = 1; retrig = 1;
    for (int j = 0; j < 4; j++) begin @(negedge clk); if (!q_o) lows++; end
    #1;
    trig_pos = 0; retrig = 0;
    chk(lows == 0, "R10", "no gap during extension", lows, 0);
    run_high(n);
    chk(n == 13, "R10", "tail from last release", n, 13);
    wait_n(4);

    // R11: external reset
    trig_pos = 1;
    wait_n(5);
    chk(q_o == 1, "R11", "pulse before reset", q_o, 1);
    ext_rst = 1;
    #1;
    chk(q_o == 0 && qn_o == 1, "R11", "immediate abort", {q_o, qn_o}, 1);
    trig_pos = 0;
    wait_n(4);
    trig_pos = 1;
    count_high(30, n);
    chk(n == 0, "R11", "trigger blocked", n, 0);
    gate = 1;
    count_high(20, n);
    chk(n == 0, "R11", "gate blocked", n, 0);
    gate = 0;
    wait_n(4);
    ext_rst = 0;
    trig_pos = 0;
    wait_n(4);
    trig_pos = 1;
    measure(lat, w);
    chk(w == 16, "R11", "one-shot after reset release", w, 16);
    trig_pos = 0;
    wait_n(4);

    chk(qn_err == 0, "R12", "qn mismatches", qn_err, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule